// File: doc/BRIEF.md
# Memory-Reference Effective Address Stage

This block forms the operand address for the load, store and load-address instructions of a small 32-bit load/store processor. Each cycle it may accept one instruction word, together with the program counter of the following instruction and the value read from the register that the base field names. One cycle later it presents the effective address and a set of registered control outputs:

- a memory-read strobe
- a memory-write strobe
- a register-write enable
- a select that tells the writeback path what goes into the destination register: the memory data or the address itself

Two addressing families are handled. The relative family adds a 22-bit signed constant to the program counter. The displacement family adds a 17-bit signed constant to a base. That base is the register value when the base field is nonzero. When the base field is zero, the base is the constant zero, so a zero field gives direct or immediate addressing rather than indexing off register 0. Opcodes outside the six handled ones produce no strobes and raise a not-handled flag, so a neighbouring unit can take them.

Top module: `mem_addr_stage`

## Requirements
- R1: The instruction fields are decoded at fixed positions:
  - opcode at bits 31:27
  - destination/source register index at bits 26:22
  - base register index at bits 21:17
  - 22-bit relative constant at bits 21:0
  - 17-bit displacement constant at bits 16:0
  - Register indices are plain binary, 0 to 31.
- R2: Opcode 2 (relative load) gives a read strobe, a register write with select 0 (memory data), and address = pc + sign-extended 22-bit constant.
- R3: Opcode 4 (relative store) gives a write strobe and no register write, at address = pc + sign-extended 22-bit constant.
- R4: Opcode 6 (relative address load) gives a register write with select 1 (address) and no memory strobe. The address is pc + sign-extended 22-bit constant.
- R5: Opcodes 1 (load), 3 (store) and 5 (address load) behave like opcodes 2, 4 and 6 respectively, but the address is base + sign-extended 17-bit constant.
- R6: When the base field is 0, the base is zero and the register value input has no effect on the address. Any nonzero base field uses the register value input.
- R7: Both constants are sign-extended to 32 bits, and every sum wraps modulo 2^32.
- R8: Any opcode other than 1 to 6 gives no read, write or register-write strobe, select 0, address 0, and raises the not-handled flag.
- R9: Outputs change on the clock edge after an input with in_valid high, and out_valid is high for exactly that one cycle. After a cycle with in_valid low, out_valid, all strobes and the not-handled flag are 0.
- R10: While reset is held, every output is 0.
- R11: out_ra carries the register index field of the accepted instruction. The read and write strobes are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction, pc and register value are valid this cycle |
| in_instr | input | 32 | Instruction word |
| in_pc | input | 32 | Address of the next instruction |
| in_rb_data | input | 32 | Contents of the register named by the base field |
| out_valid | output | 1 | Registered result valid, one-cycle pulse |
| out_addr | output | 32 | Effective address |
| out_mem_rd | output | 1 | Memory read strobe |
| out_mem_wr | output | 1 | Memory write strobe |
| out_reg_wr | output | 1 | Destination register write enable |
| out_dst_sel | output | 1 | Writeback select: 0 memory data, 1 address |
| out_unhandled | output | 1 | Opcode is not a memory-reference form |
| out_ra | output | 5 | Register index field of the instruction |

## Verification
The bench walks every one of the 32 opcodes through the following cases:
- a zero and a nonzero base field, so that a design reading register 0 as the base instead of zero returns the register value where zero belongs
- constants at their most negative and most positive values, so that zero-extension or a wrong sign bit shows up as a large address error
- program counter and base values near 2^32, where a missing wrap or an extra carry bit changes the result

Idle cycles follow each instruction, and back-to-back instructions are also applied, so that strobes that linger or a valid pulse that stretches past one cycle are caught. The bench also watches for family or strobe swaps, such as a store that also writes the register or an address-load that reads memory.

// File: rtl/mas_pkg.sv
package mas_pkg;

    // Addressing family chosen by the opcode
    typedef enum logic [1:0] {
        AM_NONE  = 2'd0,
        AM_PCREL = 2'd1,
        AM_DISP  = 2'd2
    } amode_e;

    // Per-opcode control bundle
    typedef struct packed {
        amode_e mode;
        logic   mem_rd;
        logic   mem_wr;
        logic   reg_wr;
        logic   dst_addr;
    } ctrl_t;

    // Opcode values (decoded by neighbouring pipeline logic too)
    localparam int OP_LD  = 1;
    localparam int OP_LDR = 2;
    localparam int OP_ST  = 3;
    localparam int OP_STR = 4;
    localparam int OP_LA  = 5;
    localparam int OP_LAR = 6;

endpackage

// File: rtl/mas_decode.sv
module mas_decode
    import mas_pkg::*;
#(
    parameter int OPC_W = 5
) (
    input  logic [OPC_W-1:0] opcode,
    output ctrl_t            ctrl
);

    always_comb begin
        ctrl          = '0;
        ctrl.mode     = AM_NONE;
        case (opcode)
            OPC_W'(OP_LD): begin
                ctrl.mode   = AM_DISP;
                ctrl.mem_rd = 1'b1;
                ctrl.reg_wr = 1'b1;
            end
            OPC_W'(OP_ST): begin
                ctrl.mode   = AM_DISP;
                ctrl.mem_wr = 1'b1;
            end
            OPC_W'(OP_LA): begin
                ctrl.mode     = AM_DISP;
                ctrl.reg_wr   = 1'b1;
                ctrl.dst_addr = 1'b1;
            end
            OPC_W'(OP_LDR): begin
                ctrl.mode   = AM_PCREL;
                ctrl.mem_rd = 1'b1;
                ctrl.reg_wr = 1'b1;
            end
            OPC_W'(OP_STR): begin
                ctrl.mode   = AM_PCREL;
                ctrl.mem_wr = 1'b1;
            end
            OPC_W'(OP_LAR): begin
                ctrl.mode     = AM_PCREL;
                ctrl.reg_wr   = 1'b1;
                ctrl.dst_addr = 1'b1;
            end
            default: begin
                ctrl      = '0;
                ctrl.mode = AM_NONE;
            end
        endcase
    end

endmodule

// File: rtl/mas_agen.sv
module mas_agen
    import mas_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int REG_W = 5,
    parameter int C1_W  = 22,
    parameter int C2_W  = 17
) (
    input  amode_e            mode,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   rb_data,
    input  logic [REG_W-1:0]  rb_idx,
    input  logic [C1_W-1:0]   c1,
    input  logic [C2_W-1:0]   c2,
    output logic [XLEN-1:0]   addr
);

    localparam int EXT1 = XLEN - C1_W;
    localparam int EXT2 = XLEN - C2_W;

    logic [XLEN-1:0] c1_ext;
    logic [XLEN-1:0] c2_ext;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] opnd_a;
    logic [XLEN-1:0] opnd_b;

    // Sign extension; a zero-width extension is not legal, so pick the form
    generate
        if (EXT1 > 0) begin : g_c1_ext
            assign c1_ext = {{EXT1{c1[C1_W-1]}}, c1};
        end else begin : g_c1_full
            assign c1_ext = c1[XLEN-1:0];
        end
        if (EXT2 > 0) begin : g_c2_ext
            assign c2_ext = {{EXT2{c2[C2_W-1]}}, c2};
        end else begin : g_c2_full
            assign c2_ext = c2[XLEN-1:0];
        end
    endgenerate

    // Base index zero selects the constant zero, not register 0
    assign base = (rb_idx == '0) ? '0 : rb_data;

    // Operand mux ahead of one shared adder
    always_comb begin
        case (mode)
            AM_PCREL: begin
                opnd_a = pc;
                opnd_b = c1_ext;
            end
            AM_DISP: begin
                opnd_a = base;
                opnd_b = c2_ext;
            end
            default: begin
                opnd_a = '0;
                opnd_b = '0;
            end
        endcase
    end

    assign addr = opnd_a + opnd_b;

endmodule

// File: rtl/mem_addr_stage.sv
module mem_addr_stage
    import mas_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OPC_W = 5,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [XLEN-1:0]  in_instr,
    input  logic [XLEN-1:0]  in_pc,
    input  logic [XLEN-1:0]  in_rb_data,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_addr,
    output logic             out_mem_rd,
    output logic             out_mem_wr,
    output logic             out_reg_wr,
    output logic             out_dst_sel,
    output logic             out_unhandled,
    output logic [REG_W-1:0] out_ra
);

    // Field positions derived from the widths
    localparam int OPC_LSB = XLEN - OPC_W;
    localparam int RA_LSB  = OPC_LSB - REG_W;
    localparam int RB_LSB  = RA_LSB - REG_W;
    localparam int C1_W    = RA_LSB;
    localparam int C2_W    = RB_LSB;

    typedef struct packed {
        logic             valid;
        logic [XLEN-1:0]  addr;
        logic             mem_rd;
        logic             mem_wr;
        logic             reg_wr;
        logic             dst_sel;
        logic             unhandled;
        logic [REG_W-1:0] ra;
    } stage_t;

    logic [OPC_W-1:0] f_opc;
    logic [REG_W-1:0] f_ra;
    logic [REG_W-1:0] f_rb;
    logic [C1_W-1:0]  f_c1;
    logic [C2_W-1:0]  f_c2;
    ctrl_t            dec;
    logic [XLEN-1:0]  ea;
    stage_t           st_d;
    stage_t           st_q;

    assign f_opc = in_instr[XLEN-1:OPC_LSB];
    assign f_ra  = in_instr[OPC_LSB-1:RA_LSB];
    assign f_rb  = in_instr[RA_LSB-1:RB_LSB];
    assign f_c1  = in_instr[C1_W-1:0];
    assign f_c2  = in_instr[C2_W-1:0];

    mas_decode #(.OPC_W(OPC_W)) u_dec (
        .opcode (f_opc),
        .ctrl   (dec)
    );

    mas_agen #(
        .XLEN  (XLEN),
        .REG_W (REG_W),
        .C1_W  (C1_W),
        .C2_W  (C2_W)
    ) u_agen (
        .mode    (dec.mode),
        .pc      (in_pc),
        .rb_data (in_rb_data),
        .rb_idx  (f_rb),
        .c1      (f_c1),
        .c2      (f_c2),
        .addr    (ea)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.addr      = ea;
            st_d.mem_rd    = dec.mem_rd;
            st_d.mem_wr    = dec.mem_wr;
            st_d.reg_wr    = dec.reg_wr;
            st_d.dst_sel   = dec.dst_addr;
            st_d.unhandled = (dec.mode == AM_NONE);
            st_d.ra        = f_ra;
        end else begin
            st_d.mem_rd    = 1'b0;
            st_d.mem_wr    = 1'b0;
            st_d.reg_wr    = 1'b0;
            st_d.unhandled = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid     = st_q.valid;
    assign out_addr      = st_q.addr;
    assign out_mem_rd    = st_q.mem_rd;
    assign out_mem_wr    = st_q.mem_wr;
    assign out_reg_wr    = st_q.reg_wr;
    assign out_dst_sel   = st_q.dst_sel;
    assign out_unhandled = st_q.unhandled;
    assign out_ra        = st_q.ra;

endmodule

// File: rtl/mas_checker.sv
module mas_checker #(
    parameter int XLEN  = 32,
    parameter int OPC_W = 5,
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [XLEN-1:0]  in_instr,
    input logic             out_valid,
    input logic [XLEN-1:0]  out_addr,
    input logic             out_mem_rd,
    input logic             out_mem_wr,
    input logic             out_reg_wr,
    input logic             out_dst_sel,
    input logic             out_unhandled,
    input logic [REG_W-1:0] out_ra
);

    localparam int OPC_LSB = XLEN - OPC_W;
    localparam int RA_LSB  = OPC_LSB - REG_W;
    localparam int RB_LSB  = RA_LSB - REG_W;

    logic [OPC_W-1:0] chk_opc;
    logic [REG_W-1:0] chk_ra;
    logic [REG_W-1:0] chk_rb;
    logic [XLEN-1:0]  chk_c2_ext;
    logic             chk_disp_direct;

    assign chk_opc    = in_instr[XLEN-1:OPC_LSB];
    assign chk_ra     = in_instr[OPC_LSB-1:RA_LSB];
    assign chk_rb     = in_instr[RA_LSB-1:RB_LSB];
    assign chk_c2_ext = XLEN'($signed(in_instr[RB_LSB-1:0]));
    assign chk_disp_direct = in_valid && (chk_rb == '0) &&
        (chk_opc == OPC_W'(1) || chk_opc == OPC_W'(3) || chk_opc == OPC_W'(5));

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_mem_rd || out_mem_wr || out_reg_wr || out_unhandled));

    a_r11_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_mem_rd && out_mem_wr));

    a_r11_ra_passes: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_ra == $past(chk_ra));

    a_r8_unhandled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        out_unhandled |-> !(out_mem_rd || out_mem_wr || out_reg_wr) && out_addr == '0);

    a_r6_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
        chk_disp_direct |=> out_addr == $past(chk_c2_ext));

    a_r4_addr_select_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        out_dst_sel && out_valid |-> out_reg_wr && !out_mem_rd && !out_mem_wr);

endmodule

bind mem_addr_stage mas_checker #(
    .XLEN  (XLEN),
    .OPC_W (OPC_W),
    .REG_W (REG_W)
) u_mas_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_instr      (in_instr),
    .out_valid     (out_valid),
    .out_addr      (out_addr),
    .out_mem_rd    (out_mem_rd),
    .out_mem_wr    (out_mem_wr),
    .out_reg_wr    (out_reg_wr),
    .out_dst_sel   (out_dst_sel),
    .out_unhandled (out_unhandled),
    .out_ra        (out_ra)
);

// File: tb/tb_mem_addr_stage.sv
module tb_mem_addr_stage;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_pc = '0;
    logic [31:0] in_rb_data = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic        out_mem_rd;
    logic        out_mem_wr;
    logic        out_reg_wr;
    logic        out_dst_sel;
    logic        out_unhandled;
    logic [4:0]  out_ra;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mem_addr_stage dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_instr      (in_instr),
        .in_pc         (in_pc),
        .in_rb_data    (in_rb_data),
        .out_valid     (out_valid),
        .out_addr      (out_addr),
        .out_mem_rd    (out_mem_rd),
        .out_mem_wr    (out_mem_wr),
        .out_reg_wr    (out_reg_wr),
        .out_dst_sel   (out_dst_sel),
        .out_unhandled (out_unhandled),
        .out_ra        (out_ra)
    );

    // Packed view: valid, addr, rd, wr, reg_wr, sel, unhandled, ra
    function automatic logic [42:0] actual_vec();
        return {out_valid, out_addr, out_mem_rd, out_mem_wr, out_reg_wr,
                out_dst_sel, out_unhandled, out_ra};
    endfunction

    // Expected outputs from the requirements (R1 field layout)
    function automatic logic [42:0] model(input logic [31:0] ins,
                                          input logic [31:0] pc,
                                          input logic [31:0] rbv);
        logic [4:0]  opc = ins[31:27];
        logic [4:0]  ra  = ins[26:22];
        logic [4:0]  rb  = ins[21:17];
        logic [31:0] s1  = {{10{ins[21]}}, ins[21:0]};
        logic [31:0] s2  = {{15{ins[16]}}, ins[16:0]};
        logic [31:0] bse = (rb == 5'd0) ? 32'd0 : rbv;
        logic [31:0] a   = 32'd0;
        logic rd = 0, wr = 0, rw = 0, sel = 0, unh = 0;
        case (opc)
            5'd2: begin a = pc + s1;  rd = 1; rw = 1; end            // R2
            5'd4: begin a = pc + s1;  wr = 1; end                    // R3
            5'd6: begin a = pc + s1;  rw = 1; sel = 1; end           // R4
            5'd1: begin a = bse + s2; rd = 1; rw = 1; end            // R5
            5'd3: begin a = bse + s2; wr = 1; end                    // R5
            5'd5: begin a = bse + s2; rw = 1; sel = 1; end           // R5
            default: unh = 1;                                        // R8
        endcase
        return {1'b1, a, rd, wr, rw, sel, unh, ra};
    endfunction

    function automatic string tag_of(input logic [31:0] ins);
        case (ins[31:27])
            5'd2: return "R2";
            5'd4: return "R3";
            5'd6: return "R4";
            5'd1, 5'd3, 5'd5: return (ins[21:17] == 5'd0) ? "R6" : "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [42:0] act, input logic [42:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one instruction at the falling edge; result visible a cycle later
    task automatic issue(input logic [31:0] ins, input logic [31:0] pc,
                         input logic [31:0] rbv, input bit idle_after);
        in_valid   = 1'b1;
        in_instr   = ins;
        in_pc      = pc;
        in_rb_data = rbv;
        @(negedge clk);
        if (idle_after) begin
            in_valid   = 1'b0;
            in_instr   = ~ins;
            in_rb_data = ~rbv;
        end
        check(tag_of(ins), actual_vec(), model(ins, pc, rbv));
        if (idle_after) begin
            @(negedge clk);
            // R9: after an idle input cycle, no pulse and no strobes
            check("R9", {out_valid, out_mem_rd, out_mem_wr, out_reg_wr, out_unhandled}, 5'b0);
        end
    endtask

    initial begin
        logic [31:0] consts[6];
        logic [31:0] pcs[3];
        consts = '{32'h0000_0000, 32'h0020_0000, 32'h001F_FFFF,
                   32'h0001_0000, 32'h0000_FFFF, 32'h0003_A5C3};
        pcs    = '{32'h0000_1000, 32'hFFFF_FFF0, 32'h8000_0004};

        @(negedge clk);
        // R10: every output zero under reset
        check("R10", actual_vec(), 43'd0);
        @(negedge clk);
        check("R10", actual_vec(), 43'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", {out_valid, out_mem_rd, out_mem_wr, out_reg_wr, out_unhandled}, 5'b0);

        // Sweep all opcodes (R1 positions), base field zero and nonzero (R6),
        // extreme constants and wrap-prone pc/base values (R7)
        for (int op = 0; op < 32; op++) begin
            for (int k = 0; k < 6; k++) begin
                for (int p = 0; p < 3; p++) begin
                    logic [4:0]  rb_f = (k % 2 == 0) ? 5'd0 : 5'(k * 5 + p);
                    logic [4:0]  ra_f = 5'(op + k + p);
                    logic [31:0] ins;
                    logic [31:0] rbv = (p == 1) ? 32'hFFFF_FFF8 : 32'h1234_5678 + 32'(k);
                    ins = {5'(op), ra_f, 22'd0};
                    if (op == 2 || op == 4 || op == 6)
                        ins[21:0] = consts[k][21:0];
                    else
                        ins[16:0] = consts[k][16:0];
                    ins[21:17] = (op == 2 || op == 4 || op == 6) ? ins[21:17] : rb_f;
                    issue(ins, pcs[p], rbv, (p != 2));
                end
            end
        end

        // R7: explicit wrap cases
        issue({5'd2, 5'd7, 22'h00_0010}, 32'hFFFF_FFF8, 32'd0, 1'b1);
        issue({5'd1, 5'd9, 5'd3, 17'h0_0020}, 32'd0, 32'hFFFF_FFF0, 1'b1);
        issue({5'd5, 5'd31, 5'd31, 17'h1_0000}, 32'd0, 32'h0000_0000, 1'b1);

        // R6: same instruction, zero base field, register value varied
        issue({5'd3, 5'd4, 5'd0, 17'h0_0100}, 32'd0, 32'hDEAD_BEEF, 1'b0);
        issue({5'd3, 5'd4, 5'd0, 17'h0_0100}, 32'd0, 32'h0000_0001, 1'b1);

        // R9/R11: back-to-back, then idle
        issue({5'd4, 5'd12, 22'h3F_FFFF}, 32'h0000_0100, 32'd5, 1'b0);
        issue({5'd6, 5'd13, 22'h00_0004}, 32'h0000_0200, 32'd5, 1'b0);
        issue({5'd9, 5'd14, 22'h12_3456}, 32'h0000_0300, 32'd5, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule